// File: doc/BRIEF.md
# PCI Target Burst Controller

This block is a 32-bit PCI memory target for one naturally aligned address window, backed by a small internal array of dwords. It watches for the start of a transaction. When the command is a memory read or a memory write and the address falls inside the window, it claims the transaction and runs the data phases. On writes it stores only the byte lanes that are enabled. On reads it presents complete dwords.

The low two address bits of the address phase select the burst ordering. Linear ordering walks upward through the window. Cache-line wrap ordering stays inside one aligned line and moves exactly one line of data. The reserved encodings limit the transaction to a single data phase. The target ends a burst itself by asserting STOP together with TRDY on the last phase it will accept. It then keeps its control outputs asserted until the initiator drops FRAME. It drives its control signals negated for one cycle before releasing them.

The block generates even parity for the read data. It checks the initiator's address parity, and that check covers the ordering bits. Pins that are tristate on the bus appear as separate input, output and output-enable signals.

Top module: `pci_tgt_burst`

## Requirements
- R1: While rst_ni is low, tgt_oe_o, ad_oe_o, par_oe_o and perr_o are 0, and trdy_no, devsel_no and stop_no are 1.
- R2: An address phase is the first rising edge at which frame_ni is seen low after it was high. The target claims the transaction only when two conditions hold. First, ad_i[31:AW+2] matches BASE_ADDR, where AW = log2(REGION_DW). Second, cbe_i is a memory read (0110, 1100, 1110) or a memory write (0111, 1111). A claimed transaction gets devsel_no low from the clock after the address phase, and never during it. Any other transaction leaves devsel_no high and tgt_oe_o low.
- R3: For a claimed write, trdy_no goes low together with devsel_no. On each edge where irdy_ni and trdy_no are both low, byte lane b (ad_i[8b+7:8b]) is stored when cbe_i[b] is 0.
- R4: A write data phase with cbe_i = 1111 completes normally and changes no stored byte.
- R5: For a claimed read, the cycle after the address phase is a turnaround cycle with trdy_no high and ad_oe_o low. From the next cycle, ad_oe_o is 1 and ad_o carries the whole addressed dword on all four lanes, whatever the byte enables are. Reads leave the stored data unchanged.
- R6: With ad_i[1:0] = 00 in the address phase (linear), the dword index rises by one per transfer. stop_no is low together with trdy_no on the phase at dword REGION_DW-1.
- R7: With ad_i[1:0] = 10 (line wrap), the low log2(LINE_DW) index bits count up modulo LINE_DW while the upper bits stay fixed. stop_no is low on the LINE_DW-th data phase.
- R8: With ad_i[0] = 1 (reserved), stop_no is low together with trdy_no on the first data phase.
- R9: A transfer with stop_no low while frame_ni is still low has three effects. trdy_no goes high. stop_no and devsel_no stay low until the clock after frame_ni is seen high. One cycle follows with all three negated and tgt_oe_o still 1, and then tgt_oe_o is 0.
- R10: A transfer with frame_ni high ends the transaction. The next cycle has devsel_no, trdy_no and stop_no high with tgt_oe_o 1 and ad_oe_o 0, and the cycle after that has tgt_oe_o 0.
- R11: par_oe_o equals ad_oe_o of the previous cycle. While par_oe_o is 1, par_o is the XOR of ad_o and cbe_i from the previous cycle.
- R12: For a claimed transaction, perr_o is 1 for one cycle, two cycles after the address phase. This happens when par_i in the cycle after the address phase differs from the XOR of the address-phase ad_i (including bits 1:0) and cbe_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Initiator frame, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Address/data bus as seen on the pins |
| cbe_i | input | 4 | Command / byte enables, enables active low |
| par_i | input | 1 | Parity from the initiator |
| ad_o | output | 32 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| par_o | output | 1 | Even parity for read data |
| par_oe_o | output | 1 | Output enable for par_o |
| trdy_no | output | 1 | Target ready, active low |
| devsel_no | output | 1 | Device select, active low |
| stop_no | output | 1 | Stop request, active low |
| tgt_oe_o | output | 1 | Output enable for trdy_no, devsel_no, stop_no |
| perr_o | output | 1 | Address parity mismatch pulse |

## Verification
The bench builds the block with a 16-dword window and a 4-dword line at base 0x4000_0000. With these values, a linear burst of a few phases already runs into the window end. A wrap burst longer than four phases is cut at the line boundary. Random start indices regularly land on the last dword or partway through a line. A window this small also means random writes and reads keep hitting the same dwords, so partial and empty byte enables are checked against data stored earlier.

// File: rtl/pci_tgt_pkg.sv
`timescale 1ns/1ps
package pci_tgt_pkg;

  typedef enum logic [1:0] {B_LIN, B_WRAP, B_RSVD} burst_e;

  typedef enum logic [2:0] {S_IDLE, S_RTA, S_XFER, S_HOLD, S_TAR} tstate_e;

  function automatic burst_e order_decode(input logic [1:0] lo);
    if (lo[0]) return B_RSVD;
    if (lo[1]) return B_WRAP;
    return B_LIN;
  endfunction

  function automatic logic cmd_is_rd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);
  endfunction

  function automatic logic cmd_is_wr(input logic [3:0] c);
    return (c == 4'b0111) || (c == 4'b1111);
  endfunction

endpackage

// File: rtl/pci_tgt_parity.sv
`timescale 1ns/1ps
module pci_tgt_parity #(
  parameter int W = 36
) (
  input  logic [W-1:0] d_i,
  output logic         p_o
);
  assign p_o = ^d_i;
endmodule

// File: rtl/pci_tgt_regfile.sv
`timescale 1ns/1ps
module pci_tgt_regfile #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    wbe_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
      end else if (we_i && wbe_i[b]) begin
        lane_q[waddr_i] <= wdata_i[8*b +: 8];
      end
    end

    assign rdata_o[8*b +: 8] = lane_q[raddr_i];
  end

endmodule

// File: rtl/pci_tgt_burst_seq.sv
`timescale 1ns/1ps
module pci_tgt_burst_seq
  import pci_tgt_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int LINE  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(LINE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  burst_e        mode_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] nxt_o,
  output logic          ld_last_o,
  output logic          cur_last_o,
  output logic          nxt_last_o
);

  localparam logic [AW-1:0] LMASK = AW'(LINE - 1);

  logic [AW-1:0] cur_q, nxt;
  logic [LW-1:0] beat_q;
  burst_e        mode_q;

  function automatic logic is_last(input burst_e m, input logic [AW-1:0] a,
                                   input logic [LW-1:0] b);
    case (m)
      B_WRAP:  return b == LW'(LINE - 1);
      B_RSVD:  return 1'b1;
      default: return a == AW'(DEPTH - 1);
    endcase
  endfunction

  always_comb begin
    nxt = cur_q + 1'b1;
    if (mode_q == B_WRAP) nxt = (cur_q & ~LMASK) | (nxt & LMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      beat_q <= '0;
      mode_q <= B_LIN;
    end else if (load_i) begin
      cur_q  <= start_i;
      beat_q <= '0;
      mode_q <= mode_i;
    end else if (adv_i) begin
      cur_q  <= nxt;
      beat_q <= beat_q + 1'b1;
    end
  end

  assign cur_o      = cur_q;
  assign nxt_o      = nxt;
  assign ld_last_o  = is_last(mode_i, start_i, '0);
  assign cur_last_o = is_last(mode_q, cur_q, beat_q);
  assign nxt_last_o = is_last(mode_q, nxt, beat_q + 1'b1);

  // R8: reserved order ends on the first phase
  a_r8_rsvd_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == B_RSVD) |=> cur_last_o);

  // R7: wrap never leaves its line
  a_r7_wrap_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && mode_q == B_WRAP) |=> ((cur_q & ~LMASK) == $past(cur_q & ~LMASK)));

endmodule

// File: rtl/pci_tgt_burst.sv
`timescale 1ns/1ps
module pci_tgt_burst
  import pci_tgt_pkg::*;
#(
  parameter  logic [31:0] BASE_ADDR = 32'h1000_0000,
  parameter  int          REGION_DW = 64,
  parameter  int          LINE_DW   = 8,
  localparam int          AW        = $clog2(REGION_DW),
  localparam int          AB        = AW + 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_ni,
  input  logic        irdy_ni,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_i,
  input  logic        par_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  output logic        par_o,
  output logic        par_oe_o,
  output logic        trdy_no,
  output logic        devsel_no,
  output logic        stop_no,
  output logic        tgt_oe_o,
  output logic        perr_o
);

  tstate_e       state_q;
  logic          frame_prev_q;
  logic          devsel_q, trdy_q, stop_q, tgt_oe_q, is_rd_q;
  logic          ad_oe_q, par_q, par_oe_q;
  logic          chk_q, apar_q, perr_q;
  logic [31:0]   ad_q;

  logic          addr_ph, hit, rd_cmd, wr_cmd, claim, xfer;
  logic          apar_now, dpar_now;
  logic [AW-1:0] cur_a, nxt_a, raddr;
  logic          ld_last, cur_last, nxt_last;
  logic [31:0]   rdata;

  assign addr_ph = (state_q == S_IDLE) && !frame_ni && frame_prev_q;
  assign hit     = ad_i[31:AB] == BASE_ADDR[31:AB];
  assign rd_cmd  = cmd_is_rd(cbe_i);
  assign wr_cmd  = cmd_is_wr(cbe_i);
  assign claim   = addr_ph && hit && (rd_cmd || wr_cmd);
  assign xfer    = (state_q == S_XFER) && trdy_q && !irdy_ni;
  assign raddr   = xfer ? nxt_a : cur_a;

  pci_tgt_burst_seq #(.DEPTH(REGION_DW), .LINE(LINE_DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (claim),
    .start_i    (ad_i[AB-1:2]),
    .mode_i     (order_decode(ad_i[1:0])),
    .adv_i      (xfer),
    .cur_o      (cur_a),
    .nxt_o      (nxt_a),
    .ld_last_o  (ld_last),
    .cur_last_o (cur_last),
    .nxt_last_o (nxt_last)
  );

  pci_tgt_regfile #(.DEPTH(REGION_DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (xfer && !is_rd_q),
    .waddr_i (cur_a),
    .wdata_i (ad_i),
    .wbe_i   (~cbe_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  pci_tgt_parity #(.W(36)) u_apar (.d_i({ad_i, cbe_i}), .p_o(apar_now));
  pci_tgt_parity #(.W(36)) u_dpar (.d_i({ad_q, cbe_i}), .p_o(dpar_now));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      frame_prev_q <= 1'b1;
      devsel_q     <= 1'b0;
      trdy_q       <= 1'b0;
      stop_q       <= 1'b0;
      tgt_oe_q     <= 1'b0;
      is_rd_q      <= 1'b0;
      ad_oe_q      <= 1'b0;
      ad_q         <= '0;
      par_q        <= 1'b0;
      par_oe_q     <= 1'b0;
      chk_q        <= 1'b0;
      apar_q       <= 1'b0;
      perr_q       <= 1'b0;
    end else begin
      frame_prev_q <= frame_ni;
      par_oe_q     <= ad_oe_q;
      if (ad_oe_q) par_q <= dpar_now;
      chk_q        <= 1'b0;
      perr_q       <= chk_q && (apar_q != par_i);
      if (addr_ph) apar_q <= apar_now;

      case (state_q)
        S_IDLE: if (claim) begin
          devsel_q <= 1'b1;
          tgt_oe_q <= 1'b1;
          is_rd_q  <= rd_cmd;
          chk_q    <= 1'b1;
          if (rd_cmd) begin
            state_q <= S_RTA;  // AD turnaround cycle
          end else begin
            trdy_q  <= 1'b1;
            stop_q  <= ld_last;
            state_q <= S_XFER;
          end
        end
        S_RTA: begin
          trdy_q  <= 1'b1;
          ad_oe_q <= 1'b1;
          ad_q    <= rdata;
          stop_q  <= cur_last;
          state_q <= S_XFER;
        end
        S_XFER: if (xfer) begin
          if (frame_ni) begin
            devsel_q <= 1'b0;
            trdy_q   <= 1'b0;
            stop_q   <= 1'b0;
            ad_oe_q  <= 1'b0;
            state_q  <= S_TAR;
          end else if (stop_q) begin
            trdy_q  <= 1'b0;
            ad_oe_q <= 1'b0;
            state_q <= S_HOLD;
          end else begin
            stop_q <= nxt_last;
            if (is_rd_q) ad_q <= rdata;
          end
        end
        S_HOLD: if (frame_ni) begin
          devsel_q <= 1'b0;
          stop_q   <= 1'b0;
          state_q  <= S_TAR;
        end
        S_TAR: begin
          tgt_oe_q <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ad_o      = ad_q;
  assign ad_oe_o   = ad_oe_q;
  assign par_o     = par_q;
  assign par_oe_o  = par_oe_q;
  assign trdy_no   = ~trdy_q;
  assign devsel_no = ~devsel_q;
  assign stop_no   = ~stop_q;
  assign tgt_oe_o  = tgt_oe_q;
  assign perr_o    = perr_q;

  // R2: devsel only follows an address phase
  a_r2_devsel_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(devsel_q) |-> $past(addr_ph));

  // R5: read data driven only after devsel had a cycle
  a_r5_ad_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ad_oe_q) |-> $past(devsel_q) && !$past(trdy_q));

  // R9: stop and trdy never without devsel
  a_r9_stop_needs_devsel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q || trdy_q) |-> devsel_q);

  // R10: control pins released only after a driven-negated cycle
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_oe_q) |-> $past(!devsel_q && !trdy_q && !stop_q));

  // R11: ad enable stays inside the driven window
  a_r11_ad_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_q |-> tgt_oe_q && is_rd_q);

endmodule

// File: tb/sim_pci_tgt_burst.sv
`timescale 1ns/1ps
module sim_pci_tgt_burst;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int DW = 16;
  localparam int LN = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, par_i = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic [31:0] ad_o;
  logic        ad_oe, par_o, par_oe, trdy_no, devsel_no, stop_no, tgt_oe, perr_o;

  int checks = 0, errors = 0;
  logic [31:0] model [DW];
  bit          run = 0;
  logic        prv_oe = 0;
  logic [31:0] prv_ad = '0;
  logic [3:0]  prv_cbe = '0;

  always #10 clk = ~clk;

  pci_tgt_burst #(.BASE_ADDR(BASE), .REGION_DW(DW), .LINE_DW(LN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .ad_i(ad), .cbe_i(cbe), .par_i(par_i), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .par_o(par_o), .par_oe_o(par_oe), .trdy_no(trdy_no), .devsel_no(devsel_no),
    .stop_no(stop_no), .tgt_oe_o(tgt_oe), .perr_o(perr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(input int s, input logic [1:0] o, input int k);
    if (o[0]) return s;
    if (o[1]) return (s & ~(LN - 1)) | ((s + k) & (LN - 1));
    return s + k;
  endfunction

  function automatic bit exp_last(input int s, input logic [1:0] o, input int k);
    if (o[0]) return k == 0;
    if (o[1]) return k == LN - 1;
    return s + k == DW - 1;
  endfunction

  function automatic logic [3:0] gen_be(input int m);
    if (m == 1) return 4'hF;
    if (m == 2) return 4'h0;
    return 4'($urandom);
  endfunction

  // R11 parity follows the previous cycle
  always @(negedge clk) begin
    #5;
    if (run) begin
      if (prv_oe || par_oe) chk(par_oe == prv_oe, "R11 par_oe", {31'b0, par_oe}, {31'b0, prv_oe});
      if (prv_oe && par_oe) chk(par_o == ^{prv_ad, prv_cbe}, "R11 par value",
                                {31'b0, par_o}, {31'b0, ^{prv_ad, prv_cbe}});
      prv_oe  = ad_oe;
      prv_ad  = ad_o;
      prv_cbe = cbe;
    end
  end

  task automatic burst(input int start, input logic [1:0] ord, input logic [3:0] cmd,
                       input int n, input bit rd, input int bem, input bit badp,
                       input string dtag);
    int k = 0, cyc = 0, e;
    bit done = 0, stop_seen = 0, fr = 0, last;
    logic [31:0] wd, addr;
    logic [3:0]  be;
    string tag;
    addr = BASE | 32'(start << 2) | {30'b0, ord};
    tag  = ord[0] ? "R8 stop" : (ord[1] ? "R7 stop" : "R6 stop");
    wd   = $urandom;
    be   = gen_be(bem);
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad = addr; cbe = cmd;
    #5 chk(devsel_no, "R2 no devsel in address phase", {31'b0, devsel_no}, 32'd1);
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      par_i   = (cyc == 1) ? ((^{addr, cmd}) ^ badp) : 1'b0;
      ad      = rd ? 32'h0 : wd;
      cbe     = be;
      irdy_n  = 0;
      fr      = (k == n - 1);
      frame_n = fr;
      #5;
      if (cyc == 1) begin
        chk(!devsel_no, "R2 devsel after address", {31'b0, devsel_no}, 32'd0);
        if (rd) chk(trdy_no && !ad_oe, "R5 read turnaround", {30'b0, trdy_no, ad_oe}, 32'b10);
        else    chk(!trdy_no, "R3 write trdy with devsel", {31'b0, trdy_no}, 32'd0);
      end
      if (cyc == 2) chk(perr_o == badp, "R12 address parity", {31'b0, perr_o}, {31'b0, badp});
      if (!trdy_no) begin
        e    = exp_addr(start, ord, k);
        last = exp_last(start, ord, k);
        chk(stop_no == !last, tag, {31'b0, stop_no}, {31'b0, !last});
        if (rd) begin
          chk(ad_oe && ad_o == model[e], dtag, ad_o, model[e]);
        end else begin
          for (int b = 0; b < 4; b++) if (!be[b]) model[e][8*b +: 8] = wd[8*b +: 8];
        end
        stop_seen = !stop_no;
        k++;
        if (stop_seen || k == n) done = 1;
        wd = $urandom;
        be = gen_be(bem);
      end
    end
    if (!done) chk(0, "R3 burst hung", 32'(k), 32'(n));
    @(negedge clk);
    frame_n = 1; irdy_n = 1; ad = '0; cbe = '0; par_i = 0;
    #5;
    if (cyc == 1) chk(perr_o == badp, "R12 address parity", {31'b0, perr_o}, {31'b0, badp});
    if (stop_seen && !fr) begin
      chk(!stop_no && !devsel_no && trdy_no, "R9 hold until frame",
          {29'b0, stop_no, devsel_no, trdy_no}, 32'b001);
      @(negedge clk);
      #5;
    end
    chk(devsel_no && stop_no && trdy_no && tgt_oe && !ad_oe,
        (stop_seen && !fr) ? "R9 turnaround" : "R10 turnaround",
        {27'b0, devsel_no, stop_no, trdy_no, tgt_oe, ad_oe}, 32'b11110);
    @(negedge clk);
    #5 chk(!tgt_oe, "R10 release", {31'b0, tgt_oe}, 32'd0);
  endtask

  task automatic miss(input logic [31:0] addr, input logic [3:0] cmd);
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad = addr; cbe = cmd;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      irdy_n = 0; frame_n = (i == 2); ad = '0; cbe = '0;
      #5 chk(devsel_no && !tgt_oe, "R2 ignored", {30'b0, devsel_no, tgt_oe}, 32'b10);
    end
    @(negedge clk);
    frame_n = 1; irdy_n = 1;
    #5 chk(devsel_no && !tgt_oe, "R2 ignored", {30'b0, devsel_no, tgt_oe}, 32'b10);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < DW; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #5 chk(!tgt_oe && !ad_oe && !par_oe && !perr_o && trdy_no && devsel_no && stop_no,
           "R1 reset state",
           {25'b0, tgt_oe, ad_oe, par_oe, perr_o, trdy_no, devsel_no, stop_no}, 32'b0000111);
    @(negedge clk);
    rst_ni = 1;
    run = 1;
    @(negedge clk);

    burst(0, 2'b00, 4'b0111, 4, 0, 2, 0, "R3 write data");
    burst(0, 2'b00, 4'b0110, 4, 1, 0, 0, "R5 read data");
    burst(5, 2'b10, 4'b1111, 6, 0, 2, 0, "R7 write");
    burst(6, 2'b10, 4'b1110, 6, 1, 0, 0, "R7 read data");
    burst(3, 2'b01, 4'b0111, 3, 0, 2, 0, "R8 write");
    burst(11, 2'b11, 4'b1100, 3, 1, 0, 0, "R8 read data");
    burst(0, 2'b00, 4'b0111, 2, 0, 1, 0, "R4 write");
    burst(0, 2'b00, 4'b0110, 2, 1, 0, 0, "R4 unchanged after empty enables");
    burst(8, 2'b00, 4'b0111, 8, 0, 0, 0, "R3 partial write");
    burst(8, 2'b00, 4'b1100, 8, 1, 0, 0, "R3 partial readback");
    burst(14, 2'b00, 4'b0110, 5, 1, 0, 1, "R6 region end read");
    burst(15, 2'b00, 4'b0111, 1, 0, 2, 1, "R12 single write");
    miss(BASE | 32'h0000_0100, 4'b0110);
    miss(BASE, 4'b0010);
    burst(0, 2'b00, 4'b0110, 4, 1, 0, 0, "R2 no write from ignored cycles");

    for (int t = 0; t < 60; t++) begin
      logic [1:0] o;
      logic [3:0] c;
      bit r;
      o = 2'($urandom);
      r = 1'($urandom);
      case ($urandom % 3)
        0:       c = r ? 4'b0110 : 4'b0111;
        1:       c = r ? 4'b1100 : 4'b1111;
        default: c = r ? 4'b1110 : 4'b0111;
      endcase
      burst(int'($urandom % DW), o, c, 1 + int'($urandom % 6), r, 0,
            1'($urandom % 5 == 0), "R5 random read data");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule